// File: doc/BRIEF.md
# Full-Bridge Gate Sequencer with Dead-Time Insertion

This block turns four logic-level switch commands and one shared disable into four gate-enable outputs for an H-bridge built from two half bridges, A and B. Each half bridge has a low-side and a high-side command. The block resolves conflicts between them and delays every turn-on by a programmable number of clock cycles. It never lets the two switches of one half bridge conduct together.

All commands and the disable pass through two flip-flops before any decision is made. Two delay counts set the timing. One is shared by both high-side gates and the other by both low-side gates. Turn-off is never delayed. The high side is also interlocked against the registered state of its partner gate, so a count of zero still leaves one idle cycle at every handover.

When disable is released, both low-side gates give a refresh pulse of a fixed width. The high-side gates may switch on only after a longer interval has passed. After reset the high-side gates stay blocked until disable has been asserted at least once. A typical use is complementary drive: the high-side command is held high and the low-side command alone toggles each half bridge.

Top module: `hb_gate_top`

## Requirements
- R1: While the synchronised disable is high, all four gate outputs are low whatever the other inputs are. They are low from the third rising edge after the disable pin goes high.
- R2: With disable low, a high low-side command forces the high-side gate of the same half bridge low, whatever its high-side command is.
- R3: With disable low and the low-side command low, the high-side gate follows its high-side command. With both commands low, both gates of that half bridge are low.
- R4: A gate goes low on the third rising edge after its request ends. A high-side gate whose partner is already off goes high on edge 3+H after its command rises, where H is the value on `hi_dly_i`.
- R5: A low-side gate whose partner is already off goes high on edge 3+L after its command rises, where L is the value on `lo_dly_i`. Both half bridges share the two counts.
- R6: The two gates of one half bridge are never high in the same cycle. Between one of them going low and the other going high there is at least one cycle with both low. With both counts at 0, a handover takes 4 edges from the command change to the new gate rising.
- R7: Half bridge A and half bridge B do not affect each other. They share only the disable and the two delay counts.
- R8: When the synchronised disable falls after having been high, each low-side gate is high for exactly REFRESH_CYC consecutive cycles, even with its command low.
- R9: After disable is released, a high-side gate goes high no earlier than edge 3+UPPER_CYC+H after the disable pin falls. UPPER_CYC must be greater than REFRESH_CYC.
- R10: After reset, both high-side gates stay low until the synchronised disable has been high at least once. The low-side gates operate normally during this time.
- R11: A turn-on request must stay present for the whole count. If it drops before the count completes, the gate stays low and the next request counts again from zero.
- R12: A synchronous active-high reset drives all gates low and blocks the high side. Command and disable pins are each passed through a two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dis_i | input | 1 | Shared disable; high turns all gates off |
| a_lo_i | input | 1 | Half bridge A low-side command |
| a_hi_i | input | 1 | Half bridge A high-side command |
| b_lo_i | input | 1 | Half bridge B low-side command |
| b_hi_i | input | 1 | Half bridge B high-side command |
| hi_dly_i | input | DLY_W | Turn-on delay in cycles for both high-side gates |
| lo_dly_i | input | DLY_W | Turn-on delay in cycles for both low-side gates |
| a_lo_o | output | 1 | Half bridge A low-side gate enable |
| a_hi_o | output | 1 | Half bridge A high-side gate enable |
| b_lo_o | output | 1 | Half bridge B low-side gate enable |
| b_hi_o | output | 1 | Half bridge B high-side gate enable |

## Verification
The bench first drives single commands into one half bridge with the other gate already off. This separates pure turn-on and turn-off latency from the effect of the interlock, and shows whether the high-side and low-side counts are each routed to the right gates. It then runs complementary toggling with both counts at zero, which shows whether a dead cycle is really inserted. A request shorter than the count tells a restarting counter from one that keeps its progress. Disable pulses with every command high separate the disable priority from the refresh pulse and the late upper enable. Keeping half bridge B steady while A toggles exposes any crosstalk between the two half bridges.

// File: rtl/hb_pkg.sv
package hb_pkg;

    localparam int HB_LEGS = 2;

    // One half bridge: low-side and high-side value
    typedef struct packed {
        logic lo;
        logic hi;
    } hb_pair_t;

    // Control shared by both legs, produced by the disable sequencer
    typedef struct packed {
        logic off;    // synchronised disable
        logic rfsh;   // low-side refresh window
        logic up_ok;  // high side may be requested
    } hb_seq_t;

    // Turn-on requests for one leg: low command wins, each side waits
    // for the registered partner gate to be off.
    function automatic hb_pair_t hb_arbitrate(input hb_pair_t cmd,
                                              input hb_pair_t now,
                                              input logic up_ok);
        hb_pair_t r;
        r.lo = cmd.lo & ~now.hi;
        r.hi = ~cmd.lo & cmd.hi & up_ok & ~now.lo;
        return r;
    endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/hb_ondelay.sv
module hb_ondelay #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             kill,
    input  logic             force_on,
    input  logic             req,
    input  logic [DLY_W-1:0] limit,
    output logic             on
);
    logic [DLY_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            on  <= 1'b0;
            cnt <= '0;
        end else if (force_on) begin
            on  <= 1'b1;
            cnt <= '0;
        end else if (!req) begin
            on  <= 1'b0;
            cnt <= '0;
        end else if (!on) begin
            if (cnt >= limit) on <= 1'b1;
            else              cnt <= cnt + 1'b1;
        end
    end

    // R4
    off_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (!force_on && !req) |=> !on);

    // R11
    rise_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(on) |-> $past(req || force_on));
endmodule

// File: rtl/hb_disseq.sv
module hb_disseq
    import hb_pkg::*;
#(
    parameter int REFRESH_CYC = 4,
    parameter int UPPER_CYC   = 12
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    dis,
    output hb_seq_t seq
);
    localparam int             SW   = $clog2(UPPER_CYC + 1);
    localparam logic [SW-1:0]  RF_L = SW'(REFRESH_CYC);
    localparam logic [SW-1:0]  UP_L = SW'(UPPER_CYC);

    logic [SW-1:0] since;
    logic          unblk;

    always_ff @(posedge clk) begin
        if (rst) begin
            since <= UP_L;
            unblk <= 1'b0;
        end else if (dis) begin
            since <= '0;
            unblk <= 1'b1;
        end else if (since != UP_L) begin
            since <= since + 1'b1;
        end
    end

    always_comb begin
        seq.off   = dis;
        seq.rfsh  = !dis && (since < RF_L);
        seq.up_ok = unblk && !dis && (since == UP_L);
    end

    // R8
    rfsh_on_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dis) |-> seq.rfsh);

    // R9
    up_after_rfsh_chk: assert property (@(posedge clk) disable iff (rst)
        seq.up_ok |-> !seq.rfsh);
endmodule

// File: rtl/hb_leg.sv
module hb_leg
    import hb_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  hb_pair_t         cmd,
    input  hb_seq_t          seq,
    input  logic [DLY_W-1:0] hi_lim,
    input  logic [DLY_W-1:0] lo_lim,
    output hb_pair_t         gate
);
    hb_pair_t req;
    logic     lo_on;
    logic     hi_on;

    always_comb begin
        gate.lo = lo_on;
        gate.hi = hi_on;
        req     = hb_arbitrate(cmd, gate, seq.up_ok);
    end

    hb_ondelay #(.DLY_W(DLY_W)) u_lo (
        .clk      (clk),
        .rst      (rst),
        .kill     (seq.off),
        .force_on (seq.rfsh),
        .req      (req.lo),
        .limit    (lo_lim),
        .on       (lo_on)
    );

    hb_ondelay #(.DLY_W(DLY_W)) u_hi (
        .clk      (clk),
        .rst      (rst),
        .kill     (seq.off),
        .force_on (1'b0),
        .req      (req.hi),
        .limit    (hi_lim),
        .on       (hi_on)
    );

    // R6
    no_shoot_chk: assert property (@(posedge clk) disable iff (rst)
        !(gate.lo && gate.hi));

    // R6
    gap_after_lo_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(gate.lo) |-> !gate.hi);

    // R6
    gap_after_hi_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(gate.hi) |-> !gate.lo);

    // R2
    lo_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.lo && !seq.off) |=> !gate.hi);
endmodule

// File: rtl/hb_gate_top.sv
module hb_gate_top
    import hb_pkg::*;
#(
    parameter int DLY_W       = 8,
    parameter int REFRESH_CYC = 4,
    parameter int UPPER_CYC   = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dis_i,
    input  logic             a_lo_i,
    input  logic             a_hi_i,
    input  logic             b_lo_i,
    input  logic             b_hi_i,
    input  logic [DLY_W-1:0] hi_dly_i,
    input  logic [DLY_W-1:0] lo_dly_i,
    output logic             a_lo_o,
    output logic             a_hi_o,
    output logic             b_lo_o,
    output logic             b_hi_o
);
    localparam int NSYNC = 1 + 2 * HB_LEGS;

    // R9 configuration rule
    initial assert (REFRESH_CYC > 0 && UPPER_CYC > REFRESH_CYC);

    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] syn_in;
    logic             dis_s;
    hb_pair_t         leg_cmd  [HB_LEGS];
    hb_pair_t         leg_gate [HB_LEGS];
    hb_seq_t          seq;

    assign raw_in = {dis_i, a_lo_i, a_hi_i, b_lo_i, b_hi_i};

    hb_sync #(.W(NSYNC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn_in)
    );

    always_comb begin
        dis_s          = syn_in[NSYNC-1];
        leg_cmd[0].lo  = syn_in[3];
        leg_cmd[0].hi  = syn_in[2];
        leg_cmd[1].lo  = syn_in[1];
        leg_cmd[1].hi  = syn_in[0];
    end

    hb_disseq #(
        .REFRESH_CYC (REFRESH_CYC),
        .UPPER_CYC   (UPPER_CYC)
    ) u_seq (
        .clk (clk),
        .rst (rst),
        .dis (dis_s),
        .seq (seq)
    );

    for (genvar g = 0; g < HB_LEGS; g++) begin : g_leg
        hb_leg #(.DLY_W(DLY_W)) u_leg (
            .clk    (clk),
            .rst    (rst),
            .cmd    (leg_cmd[g]),
            .seq    (seq),
            .hi_lim (hi_dly_i),
            .lo_lim (lo_dly_i),
            .gate   (leg_gate[g])
        );
    end

    assign a_lo_o = leg_gate[0].lo;
    assign a_hi_o = leg_gate[0].hi;
    assign b_lo_o = leg_gate[1].lo;
    assign b_hi_o = leg_gate[1].hi;

    // Checker-only flag: has the synchronised disable been seen since reset
    logic dis_seen_q;
    always_ff @(posedge clk) begin
        if (rst)        dis_seen_q <= 1'b0;
        else if (dis_s) dis_seen_q <= 1'b1;
    end

    // R1
    dis_off_chk: assert property (@(posedge clk) disable iff (rst)
        dis_s |=> (!a_lo_o && !a_hi_o && !b_lo_o && !b_hi_o));

    // R10
    hi_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        !dis_seen_q |-> (!a_hi_o && !b_hi_o));
endmodule

// File: tb/hb_gate_top_tb.sv
`timescale 1ns/1ps
module hb_gate_top_tb;
    localparam int DW = 8;
    localparam int RF = 4;
    localparam int UP = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dis = 1'b0, al = 1'b0, ah = 1'b0, bl = 1'b0, bh = 1'b0;
    logic [DW-1:0] hd = '0, ld = '0;
    logic alo, aho, blo, bho;

    always #10 clk = ~clk;

    hb_gate_top #(.DLY_W(DW), .REFRESH_CYC(RF), .UPPER_CYC(UP)) u_dut (
        .clk(clk), .rst(rst), .dis_i(dis),
        .a_lo_i(al), .a_hi_i(ah), .b_lo_i(bl), .b_hi_i(bh),
        .hi_dly_i(hd), .lo_dly_i(ld),
        .a_lo_o(alo), .a_hi_o(aho), .b_lo_o(blo), .b_hi_o(bho)
    );

    int    n_run = 0;
    int    n_bad = 0;
    string cur   = "R12";
    bit    mdl_ok = 0;

    // Behavioural reference: pin history, cycles since release, per-leg state
    logic [4:0] hist[$];
    int  m_since = UP;
    bit  m_unb   = 0;
    bit  m_lo[2], m_hi[2];
    int  c_lo[2], c_hi[2];

    always @(posedge clk) begin
        if (rst) begin
            hist = '{5'b0, 5'b0};
            m_since = UP; m_unb = 0;
            for (int k = 0; k < 2; k++) begin
                m_lo[k] = 0; m_hi[k] = 0; c_lo[k] = 0; c_hi[k] = 0;
            end
            mdl_ok = 1;
        end else begin
            logic [4:0] s;
            bit ds, rfw, upw, ls, hs, nl, nh;
            int ncl, nch;
            s   = hist[0];
            ds  = s[4];
            rfw = !ds && (m_since < RF);
            upw = m_unb && !ds && (m_since >= UP);
            for (int k = 0; k < 2; k++) begin
                ls = s[3-2*k];
                hs = s[2-2*k];
                ncl = c_lo[k]; nch = c_hi[k];
                if (ds)                       begin nl = 0; ncl = 0; end
                else if (rfw)                 begin nl = 1; ncl = 0; end
                else if (!(ls && !m_hi[k]))   begin nl = 0; ncl = 0; end
                else if (m_lo[k])             nl = 1;
                else if (c_lo[k] >= int'(ld)) nl = 1;
                else                          begin nl = 0; ncl = c_lo[k] + 1; end
                if (ds)                                     begin nh = 0; nch = 0; end
                else if (!(!ls && hs && upw && !m_lo[k]))   begin nh = 0; nch = 0; end
                else if (m_hi[k])             nh = 1;
                else if (c_hi[k] >= int'(hd)) nh = 1;
                else                          begin nh = 0; nch = c_hi[k] + 1; end
                m_lo[k] = nl; m_hi[k] = nh; c_lo[k] = ncl; c_hi[k] = nch;
            end
            if (ds) begin m_since = 0; m_unb = 1; end
            else if (m_since < UP) m_since = m_since + 1;
            void'(hist.pop_front());
            hist.push_back({dis, al, ah, bl, bh});
        end
    end

    always @(negedge clk) begin
        if (mdl_ok) begin
            logic [3:0] got, exp;
            got = {alo, aho, blo, bho};
            exp = {m_lo[0], m_hi[0], m_lo[1], m_hi[1]};
            n_run++;
            if (got !== exp) begin
                n_bad++;
                $display("FAIL %s model compare: actual %b expected %b at %0t", cur, got, exp, $time);
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic outp(int k);
        case (k)
            0:       return alo;
            1:       return aho;
            2:       return blo;
            default: return bho;
        endcase
    endfunction

    task automatic meas(int k, logic tgt, output int n);
        n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (outp(k) !== tgt && n < 80);
    endtask

    task automatic step();
        @(posedge clk); #5;
    endtask

    task automatic idle(int c);
        repeat (c) @(posedge clk);
        #5;
    endtask

    task automatic finish_all();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_all();
    end

    initial begin
        int n, ca, cb;
        bit seen;
        repeat (3) @(posedge clk);
        #5 rst = 1'b0;
        chk("R12 outputs after reset", {alo, aho, blo, bho}, 0);

        // R10: high side blocked until first disable, low side live
        cur = "R10";
        ah = 1; bh = 1; idle(20);
        chk("R10 A high side blocked", aho, 0);
        chk("R10 B high side blocked", bho, 0);
        al = 1; meas(0, 1, n);
        chk("R10 low side works before first disable", n, 3);
        step(); al = 0; idle(5);

        // R1: disable overrides everything
        cur = "R1";
        hd = 3; ld = 2; al = 1; bl = 1; dis = 1; idle(8);
        chk("R1 all gates off under disable", {alo, aho, blo, bho}, 0);

        // R8: refresh pulse width after release
        cur = "R8";
        al = 0; bl = 0; ah = 0; bh = 0; dis = 0;
        ca = 0; cb = 0;
        repeat (30) begin
            @(posedge clk); #1;
            if (alo) ca++;
            if (blo) cb++;
        end
        chk("R8 A refresh width", ca, RF);
        chk("R8 B refresh width", cb, RF);

        // R9: high side waits for the upper-enable interval
        cur = "R9";
        step(); hd = 0; ah = 1; dis = 1; idle(4);
        dis = 0; meas(1, 1, n);
        chk("R9 upper enable latency", n, 3 + UP);

        // R4 / R12: immediate turn-off, counted turn-on
        cur = "R4";
        hd = 5; ld = 2;
        step(); ah = 0; meas(1, 0, n);
        chk("R4 R12 turn-off after sync", n, 3);
        step(); ah = 1; meas(1, 1, n);
        chk("R4 high turn-on count", n, 3 + 5);
        step(); ah = 0; idle(4);

        // R5: low count on leg B
        cur = "R5";
        bl = 1; meas(2, 1, n);
        chk("R5 low turn-on count", n, 3 + 2);
        step(); bl = 0; meas(2, 0, n);
        chk("R5 low turn-off", n, 3);

        // R11: short request is dropped, full count afterwards
        cur = "R11";
        step(); ah = 1; idle(3); ah = 0;
        seen = 0;
        repeat (12) begin
            @(posedge clk); #1;
            if (aho) seen = 1;
        end
        chk("R11 short request ignored", seen, 0);
        step(); ah = 1; meas(1, 1, n);
        chk("R11 count restarted", n, 3 + 5);

        // R6 / R2: complementary drive with zero counts
        cur = "R6";
        hd = 0; ld = 0; bh = 1;
        step(); al = 1; meas(0, 1, n);
        chk("R6 low on after dead cycle", n, 4);
        chk("R2 high forced off by low command", aho, 0);
        step(); al = 0; meas(1, 1, n);
        chk("R6 high on after dead cycle", n, 4);
        for (int i = 0; i < 4; i++) begin
            step(); al = ~al; idle(i + 2);
        end
        idle(6);

        // R7: leg B unaffected by leg A activity
        cur = "R7";
        chk("R7 B high held", bho, 1);
        chk("R7 B low held", blo, 0);

        // R3: high follows command, both low gives both off
        cur = "R3";
        step(); al = 0; ah = 0; idle(5);
        chk("R3 A high off", aho, 0);
        chk("R3 A low off", alo, 0);
        chk("R3 B high follows command", bho, 1);
        step(); bh = 0; meas(3, 0, n);
        chk("R3 B high follows command low", n, 3);
        idle(4);

        finish_all();
    end
endmodule